// File: doc/BRIEF.md
# Merging Store Buffer

This block sits between a first-level data cache and the next memory level and holds stores that are still on their way down. A store is accepted in one cycle. It goes either into a fresh entry or into an entry that already holds the same aligned block. Each entry keeps one block address, a block-wide data image and one valid flag per byte. Entries drain to memory in the order they were created. Each drain carries the block address, the data image and a byte-enable mask, so memory writes only the bytes the processor actually stored.

Stores that fall inside a configurable I/O window are never merged. Each one takes an entry of its own. When such a store enters, every entry already present is sealed against later merges, so nothing written after the I/O store can overtake it. The entry at the head is frozen from the first cycle it is offered to memory until memory accepts it. A store to that block during this time opens a new entry.

A read miss that needs the lower level raises a request line. In that cycle the drain offer is withdrawn, so the read wins the memory port. The miss address is also compared against every pending entry. The block returns the youngest buffered value of each byte and a per-byte hit mask. A byte whose hit bit is clear must be taken from memory.

Top module: `mwb_top`

## Requirements
- R1: After synchronous reset the buffer is empty: `st_ready` is 1, `dr_valid` is 0 and `rd_hit` is all zero.
- R2: A store that is not in the I/O window is merged into an existing entry if that entry holds the same block and is neither locked, sealed nor an I/O entry. No new entry is created. The stored bytes overwrite the entry's bytes and set their valid flags.
- R3: Any other accepted store takes a new entry. `st_ready` is 0 only when all DEPTH entries are occupied and the presented store cannot merge.
- R4: Entries drain oldest first. `dr_addr` is block aligned (low log2(BLK_BYTES) bits zero) and `dr_be` equals the union of the bytes stored into the entry. Block byte b travels on `dr_data[8b+7:8b]`, and bytes never stored are driven as zero.
- R5: While `rd_req` is 1, `dr_valid` is 0 in that same cycle.
- R6: The head entry is locked from the first cycle `dr_valid` shows it until the cycle `dr_ready` takes it. Stores to its block during that time open a new entry, and its offered address, data and mask stay unchanged.
- R7: A store whose address satisfies (addr & IO_MASK) == IO_BASE always opens its own entry and is drained with `dr_io` = 1. No later store merges into it.
- R8: When an I/O store opens an entry, every entry older than it becomes sealed and accepts no further merge.
- R9: For `rd_addr`, bit b of `rd_hit` is 1 when some pending entry of that block holds valid byte b. The matching byte of `rd_data` then comes from the youngest such entry. Bytes with a clear hit bit read as zero and must come from memory.
- R10: The store word lands at word slot `st_addr[log2(BLK_BYTES)-1:2]`. Lane k of `st_data` (bits 8k+7:8k) is written to block byte 4·slot+k only when `st_be[k]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | ADDR_W | Byte address of the store word |
| st_data | input | 32 | Store word |
| st_be | input | 4 | Per-lane write strobe of the store word |
| dr_valid | output | 1 | Oldest entry offered to memory |
| dr_ready | input | 1 | Memory takes the offered entry |
| dr_addr | output | ADDR_W | Block-aligned address of the offered entry |
| dr_data | output | 8·BLK_BYTES | Block data image of the offered entry |
| dr_be | output | BLK_BYTES | Byte-enable mask of the offered entry |
| dr_io | output | 1 | Offered entry is an I/O store |
| rd_req | input | 1 | Read miss needs the memory port this cycle |
| rd_addr | input | ADDR_W | Read miss address for the lookup |
| rd_hit | output | BLK_BYTES | Bytes supplied by the buffer |
| rd_data | output | 8·BLK_BYTES | Youngest buffered bytes for the miss block |

## Verification
The bench builds the block with DEPTH = 3, which is not a power of two. This exercises the explicit pointer wrap, and the full condition is reached after only three distinct blocks. Addresses come from five cached blocks and two I/O blocks in the top window, so merges, locked-head reallocations, duplicate entries of one block and sealing happen often. Phases with memory stalled and frequent read misses reach the full-buffer stall, the withdrawn drain offer and lookups over several entries of the same block.

// File: rtl/mwb_pkg.sv
`timescale 1ns/1ps
package mwb_pkg;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = 8 * WORD_BYTES;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MERGE = 2'd1,
        ST_ALLOC = 2'd2
    } st_act_e;

    function automatic int ring_next(input int p, input int depth);
        return (p + 1 == depth) ? 0 : p + 1;
    endfunction
endpackage

// File: rtl/mwb_match.sv
`timescale 1ns/1ps
module mwb_match #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 27,
    parameter int IDX_W = 2
) (
    input  logic [DEPTH-1:0]            cand,
    input  logic [DEPTH-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]            key,
    output logic                        hit,
    output logic [IDX_W-1:0]            idx
);
    logic [DEPTH-1:0] eq;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign eq[i] = cand[i] && (tags[i] == key);
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (eq[i]) idx = IDX_W'(i);
        end
    end

    assign hit = |eq;
endmodule

// File: rtl/mwb_lookup.sv
`timescale 1ns/1ps
module mwb_lookup #(
    parameter int DEPTH     = 4,
    parameter int TAG_W     = 27,
    parameter int BLK_BYTES = 32,
    parameter int IDX_W     = 2
) (
    input  logic [DEPTH-1:0]                  vld,
    input  logic [DEPTH-1:0][TAG_W-1:0]       tags,
    input  logic [DEPTH-1:0][8*BLK_BYTES-1:0] datas,
    input  logic [DEPTH-1:0][BLK_BYTES-1:0]   masks,
    input  logic [IDX_W-1:0]                  head,
    input  logic [TAG_W-1:0]                  key,
    output logic [BLK_BYTES-1:0]              hit,
    output logic [8*BLK_BYTES-1:0]            data
);
    // walk from oldest to youngest so younger bytes overwrite older ones
    always_comb begin
        hit  = '0;
        data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            int j;
            j = (int'(head) + k) % DEPTH;
            if (vld[j] && tags[j] == key) begin
                for (int b = 0; b < BLK_BYTES; b++) begin
                    if (masks[j][b]) begin
                        hit[b]          = 1'b1;
                        data[8*b +: 8]  = datas[j][8*b +: 8];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mwb_top.sv
`timescale 1ns/1ps
module mwb_top
    import mwb_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter int              BLK_BYTES = 32,
    parameter int              DEPTH     = 4,
    parameter logic [ADDR_W-1:0] IO_MASK = ADDR_W'(32'hF000_0000),
    parameter logic [ADDR_W-1:0] IO_BASE = ADDR_W'(32'hF000_0000)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     st_valid,
    output logic                     st_ready,
    input  logic [ADDR_W-1:0]        st_addr,
    input  logic [WORD_W-1:0]        st_data,
    input  logic [WORD_BYTES-1:0]    st_be,
    output logic                     dr_valid,
    input  logic                     dr_ready,
    output logic [ADDR_W-1:0]        dr_addr,
    output logic [8*BLK_BYTES-1:0]   dr_data,
    output logic [BLK_BYTES-1:0]     dr_be,
    output logic                     dr_io,
    input  logic                     rd_req,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [BLK_BYTES-1:0]     rd_hit,
    output logic [8*BLK_BYTES-1:0]   rd_data
);
    localparam int OFF_W  = $clog2(BLK_BYTES);
    localparam int WOFF_W = $clog2(WORD_BYTES);
    localparam int SLOT_W = OFF_W - WOFF_W;
    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int BLK_W  = 8 * BLK_BYTES;
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    // entry storage
    logic [DEPTH-1:0]            e_vld, e_io, e_seal;
    logic [DEPTH-1:0][TAG_W-1:0] e_tag;
    logic [DEPTH-1:0][BLK_W-1:0] e_data;
    logic [DEPTH-1:0][BLK_BYTES-1:0] e_mask;

    logic [PTR_W-1:0] head, tail;
    logic [CNT_W-1:0] cnt;
    logic             lock_q;

    // store decode
    logic [TAG_W-1:0]     st_tag;
    logic [SLOT_W-1:0]    st_slot;
    logic                 st_is_io;
    logic [BLK_BYTES-1:0] lane_sel;
    logic [BLK_W-1:0]     lane_data;

    assign st_tag   = st_addr[ADDR_W-1:OFF_W];
    assign st_slot  = st_addr[OFF_W-1:WOFF_W];
    assign st_is_io = (st_addr & IO_MASK) == IO_BASE;

    logic unused_low;
    assign unused_low = ^{st_addr[WOFF_W-1:0], rd_addr[OFF_W-1:0]};

    always_comb begin
        lane_sel  = '0;
        lane_data = '0;
        for (int b = 0; b < BLK_BYTES; b++) begin
            if ((b / WORD_BYTES) == int'(st_slot) && st_be[b % WORD_BYTES]) begin
                lane_sel[b]         = 1'b1;
                lane_data[8*b +: 8] = st_data[8*(b % WORD_BYTES) +: 8];
            end
        end
    end

    // drain side and head lock
    logic head_live, head_locked, pop;
    logic [DEPTH-1:0] cand;

    assign head_live   = e_vld[head];
    assign dr_valid    = head_live && !rd_req;
    assign head_locked = head_live && (dr_valid || lock_q);
    assign pop         = dr_valid && dr_ready;

    assign dr_addr = {e_tag[head], {OFF_W{1'b0}}};
    assign dr_data = e_data[head];
    assign dr_be   = e_mask[head];
    assign dr_io   = e_io[head];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            cand[i] = e_vld[i] && !e_io[i] && !e_seal[i]
                      && !(head_locked && int'(head) == i);
        end
    end

    logic             m_hit;
    logic [PTR_W-1:0] m_idx;

    mwb_match #(.DEPTH(DEPTH), .TAG_W(TAG_W), .IDX_W(PTR_W)) u_match (
        .cand (cand),
        .tags (e_tag),
        .key  (st_tag),
        .hit  (m_hit),
        .idx  (m_idx)
    );

    logic can_merge, full;
    st_act_e act;

    assign can_merge = m_hit && !st_is_io;
    assign full      = int'(cnt) == DEPTH;
    assign st_ready  = !full || can_merge;

    always_comb begin
        act = ST_IDLE;
        if (st_valid && st_ready) act = can_merge ? ST_MERGE : ST_ALLOC;
    end

    mwb_lookup #(.DEPTH(DEPTH), .TAG_W(TAG_W), .BLK_BYTES(BLK_BYTES), .IDX_W(PTR_W)) u_lookup (
        .vld   (e_vld),
        .tags  (e_tag),
        .datas (e_data),
        .masks (e_mask),
        .head  (head),
        .key   (rd_addr[ADDR_W-1:OFF_W]),
        .hit   (rd_hit),
        .data  (rd_data)
    );

    logic alloc;
    assign alloc = (act == ST_ALLOC);

    always_ff @(posedge clk) begin
        if (rst) begin
            e_vld  <= '0;
            e_io   <= '0;
            e_seal <= '0;
            e_tag  <= '0;
            e_data <= '0;
            e_mask <= '0;
            head   <= '0;
            tail   <= '0;
            cnt    <= '0;
            lock_q <= 1'b0;
        end else begin
            if (act == ST_MERGE) begin
                for (int b = 0; b < BLK_BYTES; b++) begin
                    if (lane_sel[b]) e_data[m_idx][8*b +: 8] <= lane_data[8*b +: 8];
                end
                e_mask[m_idx] <= e_mask[m_idx] | lane_sel;
            end
            if (alloc) begin
                if (st_is_io) begin
                    for (int i = 0; i < DEPTH; i++) e_seal[i] <= 1'b1;
                end
                e_vld[tail]  <= 1'b1;
                e_io[tail]   <= st_is_io;
                e_seal[tail] <= 1'b0;
                e_tag[tail]  <= st_tag;
                e_data[tail] <= lane_data;
                e_mask[tail] <= lane_sel;
                tail         <= PTR_W'(ring_next(int'(tail), DEPTH));
            end
            if (pop) begin
                e_vld[head] <= 1'b0;
                head        <= PTR_W'(ring_next(int'(head), DEPTH));
                lock_q      <= 1'b0;
            end else if (dr_valid) begin
                lock_q <= 1'b1;
            end
            cnt <= cnt + CNT_W'(alloc) - CNT_W'(pop);
        end
    end
endmodule

// File: rtl/mwb_check.sv
`timescale 1ns/1ps
module mwb_check #(
    parameter int                ADDR_W    = 32,
    parameter int                BLK_BYTES = 32,
    parameter int                DEPTH     = 4,
    parameter logic [ADDR_W-1:0] IO_MASK   = ADDR_W'(32'hF000_0000),
    parameter logic [ADDR_W-1:0] IO_BASE   = ADDR_W'(32'hF000_0000)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   st_valid,
    input logic                   st_ready,
    input logic [ADDR_W-1:0]      st_addr,
    input logic                   dr_valid,
    input logic                   dr_ready,
    input logic [ADDR_W-1:0]      dr_addr,
    input logic [8*BLK_BYTES-1:0] dr_data,
    input logic [BLK_BYTES-1:0]   dr_be,
    input logic                   rd_req,
    input logic [$clog2(DEPTH+1)-1:0] cnt
);
    localparam int OFF_W = $clog2(BLK_BYTES);

    logic io_in;
    assign io_in = (st_addr & IO_MASK) == IO_BASE;

    AST_READ_WINS: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> !dr_valid) else $error("read priority violated"); // R5

    AST_OFFER_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (dr_valid && !dr_ready) |=> (!dr_valid ||
            ($stable(dr_addr) && $stable(dr_data) && $stable(dr_be))))
        else $error("offered entry changed"); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) <= DEPTH) else $error("occupancy beyond depth"); // R3

    AST_READY_WITH_ROOM: assert property (@(posedge clk) disable iff (rst)
        (int'(cnt) < DEPTH) |-> st_ready) else $error("stall with free entry"); // R3

    AST_IO_OWN_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (st_valid && st_ready && io_in) |=>
            (int'(cnt) == int'($past(cnt)) + 1 - ($past(dr_valid && dr_ready) ? 1 : 0)))
        else $error("I/O store did not open an entry"); // R7

    AST_BLOCK_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        dr_valid |-> (dr_addr[OFF_W-1:0] == '0)) else $error("unaligned drain"); // R4
endmodule

bind mwb_top mwb_check #(
    .ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .DEPTH(DEPTH),
    .IO_MASK(IO_MASK), .IO_BASE(IO_BASE)
) u_chk (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr), .dr_data(dr_data),
    .dr_be(dr_be), .rd_req(rd_req), .cnt(cnt)
);

// File: tb/mwb_top_test.sv
`timescale 1ns/1ps
module mwb_top_test;
    localparam int DEP = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         st_valid = 1'b0;
    logic         st_ready;
    logic [31:0]  st_addr = '0;
    logic [31:0]  st_data = '0;
    logic [3:0]   st_be = '0;
    logic         dr_valid;
    logic         dr_ready = 1'b0;
    logic [31:0]  dr_addr;
    logic [255:0] dr_data;
    logic [31:0]  dr_be;
    logic         dr_io;
    logic         rd_req = 1'b0;
    logic [31:0]  rd_addr = '0;
    logic [31:0]  rd_hit;
    logic [255:0] rd_data;

    always #10 clk = ~clk;

    mwb_top #(.ADDR_W(32), .BLK_BYTES(32), .DEPTH(DEP),
              .IO_MASK(32'hF000_0000), .IO_BASE(32'hF000_0000)) uut (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_data(st_data), .st_be(st_be),
        .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr),
        .dr_data(dr_data), .dr_be(dr_be), .dr_io(dr_io),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_data(rd_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model: queue of pending entries, front = oldest
    logic [26:0]  q_tag[$];
    logic [255:0] q_data[$];
    logic [31:0]  q_msk[$];
    bit           q_io[$];
    bit           q_seal[$];
    bit           m_lock = 0;

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pick_addr();
        int sel;
        logic [31:0] a;
        sel = $urandom % 7;
        if (sel < 5) a = 32'h0000_1000 + 32'(sel) * 32;
        else a = 32'hF000_0040 + 32'(sel - 5) * 32;
        a[4:2] = 3'($urandom % 8);
        return a;
    endfunction

    task automatic cycle(input int p_st, input int p_rdy, input int p_rd);
        int sz, mi;
        bit hv, e_dv, lockd, s_io, e_rdy, acc, popx;
        logic [26:0]  s_tag;
        logic [255:0] wdat, lk_dat;
        logic [31:0]  wmsk, lk_hit;

        @(negedge clk);
        st_valid = ($urandom % 100) < p_st;
        st_addr  = pick_addr();
        st_data  = $urandom;
        st_be    = 4'(1 + $urandom % 15);
        dr_ready = ($urandom % 100) < p_rdy;
        rd_req   = ($urandom % 100) < p_rd;
        rd_addr  = pick_addr();
        #1;

        sz    = q_tag.size();
        hv    = sz > 0;
        e_dv  = hv && !rd_req;
        lockd = hv && (e_dv || m_lock);
        s_io  = st_addr[31:28] == 4'hF;
        s_tag = st_addr[31:5];
        mi    = -1;
        if (!s_io) begin
            for (int k = 0; k < sz; k++) begin
                if (q_tag[k] == s_tag && !q_io[k] && !q_seal[k] && !(k == 0 && lockd)) mi = k;
            end
        end
        e_rdy = (sz < DEP) || (mi >= 0);

        lk_hit = '0;
        lk_dat = '0;
        for (int k = 0; k < sz; k++) begin
            if (q_tag[k] == rd_addr[31:5]) begin
                for (int b = 0; b < 32; b++) begin
                    if (q_msk[k][b]) begin
                        lk_hit[b] = 1'b1;
                        lk_dat[8*b +: 8] = q_data[k][8*b +: 8];
                    end
                end
            end
        end

        chk("R3 st_ready", 256'(st_ready), 256'(e_rdy));
        chk("R5 dr_valid", 256'(dr_valid), 256'(e_dv));
        if (e_dv) begin
            chk("R4 R6 dr_addr", 256'(dr_addr), 256'({q_tag[0], 5'd0}));
            chk("R2 R4 R10 dr_be", 256'(dr_be), 256'(q_msk[0]));
            chk("R2 R8 R10 dr_data", dr_data, q_data[0]);
            chk("R7 dr_io", 256'(dr_io), 256'(q_io[0]));
        end
        chk("R9 rd_hit", 256'(rd_hit), 256'(lk_hit));
        chk("R9 rd_data", rd_data, lk_dat);

        // advance the model to the state after the coming edge
        acc  = st_valid && e_rdy;
        popx = e_dv && dr_ready;
        wdat = '0;
        wmsk = '0;
        for (int k = 0; k < 4; k++) begin
            if (st_be[k]) begin
                int b;
                b = int'(st_addr[4:2]) * 4 + k;
                wdat[8*b +: 8] = st_data[8*k +: 8];
                wmsk[b] = 1'b1;
            end
        end
        if (acc && mi >= 0) begin
            for (int b = 0; b < 32; b++) begin
                if (wmsk[b]) q_data[mi][8*b +: 8] = wdat[8*b +: 8];
            end
            q_msk[mi] = q_msk[mi] | wmsk;
        end
        if (acc && mi < 0 && s_io) begin
            for (int k = 0; k < sz; k++) q_seal[k] = 1;
        end
        if (popx) begin
            void'(q_tag.pop_front());
            void'(q_data.pop_front());
            void'(q_msk.pop_front());
            void'(q_io.pop_front());
            void'(q_seal.pop_front());
            m_lock = 0;
        end else if (e_dv) begin
            m_lock = 1;
        end
        if (acc && mi < 0) begin
            q_tag.push_back(s_tag);
            q_data.push_back(wdat);
            q_msk.push_back(wmsk);
            q_io.push_back(s_io);
            q_seal.push_back(0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 st_ready after reset", 256'(st_ready), 256'(1));
        chk("R1 dr_valid after reset", 256'(dr_valid), 256'(0));
        chk("R1 rd_hit after reset", 256'(rd_hit), 256'(0));

        repeat (1500) cycle(70, 60, 10);   // balanced traffic
        repeat (1500) cycle(80, 5, 10);    // memory mostly stalled, buffer fills
        repeat (1500) cycle(60, 50, 60);   // frequent read misses
        repeat (1500) cycle(30, 90, 5);    // light stores, fast drain
        repeat (1500) cycle(90, 20, 30);   // heavy stores, slow drain
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule